// File: doc/BRIEF.md
# Four-Level Phase-Leg Gate Pattern Generator

This block drives the six switches of one phase leg in a four-level converter. Its input is an unsigned fixed-point phase reference, scaled so that 0.0 stands for the negative rail and 3.0 for the full bus. Once per carrier period the reference is split into an integer part and a fractional part. The integer part selects the lower of two adjacent output levels. The fractional part sets how long the upper level is held. A symmetric triangle carrier is compared against that duty to pick, on every cycle, which of the two levels the leg should show.

The chosen level drives the six gates through a fixed switch-state table. Each adjacent-level step toggles exactly one complementary pair. The block adds a programmable blanking interval on that pair: both of its gates stay low before the incoming gate rises. The other two pairs keep their state the whole time. When the target is more than one level away, the leg walks there one level at a time, and each step gets its own blanking interval.

Top module: `fourlvl_leg_pwm`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the gates show the level-0 pattern, sw_o = 6'b101010.
- R2: ref_i is unsigned with FRAC_W fractional bits, and its top two bits are the integer part. The lower level equals the integer part, and the duty is frac / 2^FRAC_W. The carrier period is 2^(FRAC_W+1) clock cycles. With dt_i = 0, the upper-level pattern appears for exactly 2*frac cycles per period and the lower-level pattern for the rest.
- R3: The gate patterns are sw_o = 6'b101010 for level 0, 6'b011010 for level 1, 6'b010110 for level 2 and 6'b010101 for level 3. Bit 0 is the switch to the positive rail and bit 5 the switch to the negative rail. The complementary pairs are bits {0,1}, {2,3} and {4,5}.
- R4: The reference is captured only at the carrier peak. Any change to ref_i between two peaks has no effect on the gates.
- R5: A reference of 3.0 or above is treated as level 2 with full duty, so the level-3 pattern is held for the whole period.
- R6: On each level step, only the pair whose bits differ goes both-low, and it stays both-low for dt_i cycles; the other pairs are unchanged. With steady duty, each period holds 2*frac-dt_i upper-level cycles, 2^(FRAC_W+1)-2*frac-dt_i lower-level cycles and 2*dt_i blanked cycles.
- R7: No complementary pair ever has both gates high.
- R8: The leg level never moves by more than one step at a time. A step, once started, completes before the next one begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_i | input | FRAC_W+2 | Phase reference, unsigned, 2 integer bits and FRAC_W fraction bits |
| dt_i | input | DT_W | Blanking length in cycles, 0 means an immediate swap |
| sw_o | output | 6 | Gate commands, bit 0 to the positive-rail switch, bit 5 to the negative-rail switch |

## Verification
Two functions can fall in the same cycle: the blanking interval of one step, and a carrier crossing that calls for the next step. When the reference jumps across levels, the sequencer must still be blanking one pair while the target already asks for a further step. The bench provokes this by moving the reference from 0.0 straight to 2.75 with non-zero blanking. It also applies duties close to both ends of the carrier. A monitor watches every cycle for more than one pair changing at once, for a level jump larger than one, and for a pair with both gates high. The per-period counts of upper, lower and blanked cycles must then match the R6 formula exactly.

// File: rtl/leg_pwm_pkg.sv
package leg_pwm_pkg;

    typedef logic [5:0] gate_t;

    // Switch-state table: one complementary pair differs between adjacent levels.
    function automatic gate_t lvl_gates(input logic [1:0] lvl);
        gate_t g;
        case (lvl)
            2'd0:    g = 6'b101010;
            2'd1:    g = 6'b011010;
            2'd2:    g = 6'b010110;
            default: g = 6'b010101;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/leg_carrier.sv
module leg_carrier #(
    parameter int FRAC_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FRAC_W+1:0]   ref_i,
    output logic [1:0]          tgt_lvl_o
);
    localparam int REF_W = FRAC_W + 2;
    localparam logic [FRAC_W-1:0] CNT_TOP  = '1;
    localparam logic [FRAC_W:0]   DUTY_FUL = {1'b1, {FRAC_W{1'b0}}};

    typedef struct packed {
        logic [FRAC_W-1:0] cnt;
        logic              up;
        logic [1:0]        lvl;
        logic [FRAC_W:0]   duty;
    } car_t;

    car_t car_d, car_q;
    logic peak;
    logic upper_sel;

    always_comb begin
        car_d = car_q;
        peak  = car_q.up && (car_q.cnt == CNT_TOP);
        // Triangle with repeated end points: every value is visited twice.
        if (car_q.up) begin
            if (car_q.cnt == CNT_TOP) car_d.up  = 1'b0;
            else                      car_d.cnt = car_q.cnt + 1'b1;
        end else begin
            if (car_q.cnt == '0)      car_d.up  = 1'b1;
            else                      car_d.cnt = car_q.cnt - 1'b1;
        end
        if (peak) begin
            if (ref_i[REF_W-1:FRAC_W] == 2'd3) begin
                car_d.lvl  = 2'd2;
                car_d.duty = DUTY_FUL;
            end else begin
                car_d.lvl  = ref_i[REF_W-1:FRAC_W];
                car_d.duty = {1'b0, ref_i[FRAC_W-1:0]};
            end
        end
        upper_sel = car_q.duty > {1'b0, car_q.cnt};
        tgt_lvl_o = car_q.lvl + {1'b0, upper_sel};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car_q.cnt  <= '0;
            car_q.up   <= 1'b1;
            car_q.lvl  <= 2'd0;
            car_q.duty <= '0;
        end else begin
            car_q <= car_d;
        end
    end

    AST_LVL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        car_q.lvl != 2'd3); // R5

    AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !peak |=> ($stable(car_q.lvl) && $stable(car_q.duty))); // R4

endmodule

// File: rtl/leg_step_seq.sv
module leg_step_seq
    import leg_pwm_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      tgt_lvl_i,
    input  logic [DT_W-1:0] dt_i,
    output logic [5:0]      gates_o
);
    localparam logic [DT_W-1:0] DT_ONE = DT_W'(1);

    typedef struct packed {
        logic [1:0]      cur;
        logic            busy;
        logic [DT_W-1:0] cnt;
        logic [1:0]      nxt;
        gate_t           gates;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [1:0] step_lvl;

    always_comb begin
        seq_d    = seq_q;
        step_lvl = (tgt_lvl_i > seq_q.cur) ? seq_q.cur + 2'd1 : seq_q.cur - 2'd1;
        if (seq_q.busy) begin
            if (seq_q.cnt == DT_ONE) begin
                seq_d.busy  = 1'b0;
                seq_d.cnt   = '0;
                seq_d.cur   = seq_q.nxt;
                seq_d.gates = lvl_gates(seq_q.nxt);
            end else begin
                seq_d.cnt = seq_q.cnt - DT_ONE;
            end
        end else if (tgt_lvl_i != seq_q.cur) begin
            if (dt_i == '0) begin
                seq_d.cur   = step_lvl;
                seq_d.gates = lvl_gates(step_lvl);
            end else begin
                seq_d.busy  = 1'b1;
                seq_d.cnt   = dt_i;
                seq_d.nxt   = step_lvl;
                // Common bits survive, the toggling pair drops to both-low.
                seq_d.gates = lvl_gates(seq_q.cur) & lvl_gates(step_lvl);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.cur   <= 2'd0;
            seq_q.busy  <= 1'b0;
            seq_q.cnt   <= '0;
            seq_q.nxt   <= 2'd0;
            seq_q.gates <= lvl_gates(2'd0);
        end else begin
            seq_q <= seq_d;
        end
    end

    assign gates_o = seq_q.gates;

    AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !((gates_o[0] & gates_o[1]) | (gates_o[2] & gates_o[3]) | (gates_o[4] & gates_o[5]))); // R7

    AST_ONE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones({gates_o[1:0] != $past(gates_o[1:0]),
                             gates_o[3:2] != $past(gates_o[3:2]),
                             gates_o[5:4] != $past(gates_o[5:4])}) <= 1); // R6

    AST_DT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && seq_q.cnt > DT_ONE) |=> (seq_q.busy && $stable(gates_o))); // R6

    AST_ADJ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (seq_q.cur == $past(seq_q.cur)
               || {1'b0, seq_q.cur} == {1'b0, $past(seq_q.cur)} + 3'd1
               || {1'b0, seq_q.cur} + 3'd1 == {1'b0, $past(seq_q.cur)})); // R8

    AST_STEP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.busy |=> (seq_q.busy || seq_q.cur == $past(seq_q.nxt))); // R8

endmodule

// File: rtl/fourlvl_leg_pwm.sv
module fourlvl_leg_pwm #(
    parameter int FRAC_W = 6,
    parameter int DT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAC_W+1:0] ref_i,
    input  logic [DT_W-1:0]   dt_i,
    output logic [5:0]        sw_o
);
    logic [1:0] tgt_lvl;

    leg_carrier #(.FRAC_W(FRAC_W)) u_carrier (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_i     (ref_i),
        .tgt_lvl_o (tgt_lvl)
    );

    leg_step_seq #(.DT_W(DT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tgt_lvl_i (tgt_lvl),
        .dt_i      (dt_i),
        .gates_o   (sw_o)
    );

endmodule

// File: tb/fourlvl_leg_pwm_tb.sv
module fourlvl_leg_pwm_tb;
    localparam int FRAC_W = 6;
    localparam int DT_W   = 4;
    localparam int PER    = 2 ** (FRAC_W + 1);
    localparam int NV     = 10;

    // ref, dt, lower level, expected upper / lower / blanked cycles per period
    localparam int V_REF[NV]  = '{0,   77,  160, 48, 80, 192, 224, 128, 188, 64};
    localparam int V_DT[NV]   = '{0,   0,   0,   3,  5,  4,   2,   7,   2,   1};
    localparam int V_LVL[NV]  = '{0,   1,   2,   0,  1,  2,   2,   2,   2,   1};
    localparam int V_HI[NV]   = '{0,   26,  64,  93, 27, 128, 128, 0,   118, 0};
    localparam int V_LO[NV]   = '{128, 102, 64,  29, 91, 0,   0,   128, 6,   128};
    localparam int V_DD[NV]   = '{0,   0,   0,   6,  10, 0,   0,   0,   4,   0};
    localparam int V_REQ[NV]  = '{2,   2,   3,   6,  6,  5,   5,   2,   6,   3};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [FRAC_W+1:0] ref_v = '0;
    logic [DT_W-1:0]   dt_v = '0;
    logic [5:0]        sw;

    always #5 clk = ~clk;

    fourlvl_leg_pwm #(.FRAC_W(FRAC_W), .DT_W(DT_W)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_i (ref_v),
        .dt_i  (dt_v),
        .sw_o  (sw)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int excl_err = 0, pair_err = 0, jump_err = 0;
    int last_lvl = -1;
    logic [5:0] prev_sw = '0;
    bit have_prev = 1'b0;

    function automatic logic [5:0] pat(input int l);
        case (l)
            0:       return 6'b101010;
            1:       return 6'b011010;
            2:       return 6'b010110;
            default: return 6'b010101;
        endcase
    endfunction

    function automatic int decode(input logic [5:0] g);
        for (int l = 0; l < 4; l++) if (g == pat(l)) return l;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input int l, output int hi, output int lo, output int dd);
        hi = 0; lo = 0; dd = 0;
        for (int k = 0; k < PER; k++) begin
            @(negedge clk);
            if (sw == pat(l + 1))  hi++;
            else if (sw == pat(l)) lo++;
            else                   dd++;
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Continuous watch on pair exclusivity, single-pair changes and level jumps.
    always @(negedge clk) begin
        if (!rst_n) begin
            have_prev = 1'b0;
            last_lvl  = -1;
        end else begin
            int chg;
            int l;
            if ((sw[0] & sw[1]) | (sw[2] & sw[3]) | (sw[4] & sw[5])) excl_err++;
            if (have_prev) begin
                chg = int'(sw[1:0] != prev_sw[1:0]) + int'(sw[3:2] != prev_sw[3:2])
                    + int'(sw[5:4] != prev_sw[5:4]);
                if (chg > 1) pair_err++;
            end
            l = decode(sw);
            if (l >= 0) begin
                if (last_lvl >= 0 && (l - last_lvl > 1 || last_lvl - l > 1)) jump_err++;
                last_lvl = l;
            end
            prev_sw   = sw;
            have_prev = 1'b1;
        end
    end

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int hi, lo, dd;
        // R1: reset pattern
        repeat (3) @(negedge clk);
        chk(sw == 6'b101010, "R1 reset", int'(sw), int'(6'b101010));
        rst_n = 1'b1;
        @(negedge clk);
        chk(sw == 6'b101010, "R1 after release", int'(sw), int'(6'b101010));

        // Vector table: R2 R3 R5 R6
        for (int i = 0; i < NV; i++) begin
            ref_v = (FRAC_W + 2)'(V_REF[i]);
            dt_v  = DT_W'(V_DT[i]);
            repeat (3 * PER) @(negedge clk);
            measure(V_LVL[i], hi, lo, dd);
            chk(hi == V_HI[i], $sformatf("R%0d vec%0d upper", V_REQ[i], i), hi, V_HI[i]);
            chk(lo == V_LO[i], $sformatf("R%0d vec%0d lower", V_REQ[i], i), lo, V_LO[i]);
            chk(dd == V_DD[i], $sformatf("R%0d vec%0d blank", V_REQ[i], i), dd, V_DD[i]);
        end

        // R8: multi-level jump 0.0 -> 2.75 with blanking
        ref_v = '0;
        dt_v  = 4'd3;
        repeat (3 * PER) @(negedge clk);
        ref_v = 8'd176;
        repeat (3 * PER) @(negedge clk);
        measure(2, hi, lo, dd);
        chk(hi == 93, "R8 jump upper", hi, 93);
        chk(lo == 29, "R8 jump lower", lo, 29);
        chk(dd == 6,  "R8 jump blank", dd, 6);

        // R4: short glitch on ref_i far from the carrier peak has no effect
        ref_v = 8'd80;
        dt_v  = 4'd0;
        repeat (3 * PER) @(negedge clk);
        while ((cyc % PER) != 100) @(negedge clk);
        fork
            measure(1, hi, lo, dd);
            begin
                repeat (20) @(negedge clk);
                ref_v = 8'd0;
                repeat (6) @(negedge clk);
                ref_v = 8'd80;
            end
        join
        chk(hi == 32, "R4 glitch upper", hi, 32);
        chk(lo == 96, "R4 glitch lower", lo, 96);

        // R1: reset in operation returns to level 0
        ref_v = 8'd200;
        repeat (3 * PER) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(sw == 6'b101010, "R1 reset in run", int'(sw), int'(6'b101010));
        rst_n = 1'b1;

        // Monitors: R7 exclusivity, R6 single pair, R8 adjacency
        chk(excl_err == 0, "R7 pair both high", excl_err, 0);
        chk(pair_err == 0, "R6 multi-pair change", pair_err, 0);
        chk(jump_err == 0, "R8 level jump", jump_err, 0);

        summary();
        $finish;
    end

endmodule